// File: doc/BRIEF.md
# JTAG User-Register Bridge

This block sits behind a JTAG user data register and lets a host reach a small bank of 32-bit registers and a queue of results. The TAP controller lives outside. It hands the bridge one-cycle capture, shift and update strobes in the bridge's clock domain, along with the serial input bit. The bridge returns the serial output bit.

Every data-register scan is collected into one shift register, and its length is counted. On update, a 38-bit frame with a set write flag and odd parity becomes a one-cycle write on the register-file port. A 6-bit frame with a clear write flag and odd parity becomes a pending read. The next capture loads the selected value into a 32-bit output register, which the following scan shifts out LSB first.

The bank itself is external. Its read port is driven by an address from the bridge and returns data combinationally. Address 11 doubles as the job trigger. Address 0xD holds the clock word, which software writes as twice the multiplier. Address 0xE is special on reads: it drains a 16-entry result FIFO that the compute core fills.

Top module: `jtag_regbridge`

## Requirements
- R1: A 38-bit scan carries data in bits 0–31 (first shifted bit is bit 0), the address in bits 32–35, a write flag in bit 36 and parity in bit 37. If the flag is 1 and parity is good, `reg_wr_en` is high for exactly one cycle, the cycle after the update strobe is sampled, carrying that address and data.
- R2: Parity is good when the frame, parity bit included, holds an odd number of ones. A frame with bad parity causes neither a write nor a read.
- R3: A 38-bit frame with bit 36 clear is ignored. A scan of any length other than 6 or 38 bits is ignored.
- R4: A 6-bit read frame carries the address in bits 0–3, 0 in bit 4 and parity in bit 5. At the next capture, the value on `reg_rd_data` for `reg_rd_addr` is loaded. During the following shift cycles, `tdo` presents it LSB first, with bit i valid in shift cycle i.
- R5: A valid write to address 11 raises `job_start` in the same cycle as its `reg_wr_en` pulse. Writes to other addresses, including the clock word at 0xD, do not raise it.
- R6: A read of address 0xE returns the oldest FIFO entry and removes exactly that one entry. If the FIFO is empty, it returns 0xFFFFFFFF and removes nothing.
- R7: The FIFO holds 16 entries. A result pushed while it is full, with no pop in the same cycle, is dropped. `result_overflow` then rises and stays high until reset.
- R8: After reset, `tdo` is 1, `reg_wr_en`, `job_start` and `result_overflow` are 0, and the FIFO is empty. A capture with no valid read pending loads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock; all strobes are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| dr_capture | input | 1 | Capture strobe of the data register |
| dr_shift | input | 1 | Shift strobe, one per bit |
| dr_update | input | 1 | Update strobe ending a scan |
| tdi | input | 1 | Serial input bit |
| tdo | output | 1 | Serial output bit |
| reg_wr_en | output | 1 | Register-file write strobe |
| reg_wr_addr | output | 4 | Register-file write address |
| reg_wr_data | output | 32 | Register-file write data |
| job_start | output | 1 | Pulse on a write to the final message word |
| reg_rd_addr | output | 4 | Register-file read address (last read request) |
| reg_rd_data | input | 32 | Register-file read data for `reg_rd_addr` |
| result_valid | input | 1 | Push strobe from the compute core |
| result_data | input | 32 | Result word to queue |
| result_overflow | output | 1 | Sticky flag: a result was dropped |

## Verification
A write appears on the register port one cycle after the update strobe is sampled, so the bench checks `reg_wr_en`, the address, the data and `job_start` at the first falling edge after that update cycle. Read data and any FIFO pop take effect at the capture edge. The bench therefore reads `tdo` bit i at the falling edge that opens shift cycle i, before that cycle's shifting edge. Results pushed into the FIFO are visible from the edge that samples `result_valid`, and the bench always leaves idle cycles between a push and the capture that reads it.

// File: rtl/ujb_pkg.sv
// Shared constants for the JTAG user-register bridge.
// Assumes 4-bit register addresses and 32-bit register words.
package ujb_pkg;
    localparam int UJB_DATA_W      = 32;
    localparam int UJB_ADDR_W      = 4;
    localparam int UJB_FIFO_DEPTH  = 16;
    localparam int UJB_JOB_ADDR    = 11;
    localparam int UJB_RESULT_ADDR = 14;
endpackage

// File: rtl/ujb_frame_rx.sv
// Collects a data-register scan and decodes it on update.
// Decodes write frames (DATA_W+ADDR_W+2 bits) and read frames (ADDR_W+2 bits).
// Assumes capture, shift and update are one-cycle strobes in the clk domain.
module ujb_frame_rx
    import ujb_pkg::*;
#(
    parameter int DATA_W   = UJB_DATA_W,
    parameter int ADDR_W   = UJB_ADDR_W,
    parameter int JOB_ADDR = UJB_JOB_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              tdi_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              job_start_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o
);
    localparam int WR_LEN = DATA_W + ADDR_W + 2;
    localparam int RD_LEN = ADDR_W + 2;
    localparam int CNT_W  = $clog2(WR_LEN + 2);

    logic [WR_LEN-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [RD_LEN-1:0] rd_frame;
    logic              wr_ok, rd_ok;
    logic [ADDR_W-1:0] frame_addr;

    // Shift register (first bit ends at bit 0) and saturating bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (capture_i) begin
            cnt_q <= '0;
        end else if (shift_i) begin
            sr_q <= {tdi_i, sr_q[WR_LEN-1:1]};
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Frame decode: length, odd parity and the write flag must all match.
    always_comb begin
        rd_frame   = sr_q[WR_LEN-1 -: RD_LEN];
        frame_addr = sr_q[DATA_W +: ADDR_W];
        wr_ok = update_i && (cnt_q == CNT_W'(WR_LEN)) && (^sr_q) && sr_q[WR_LEN-2];
        rd_ok = update_i && (cnt_q == CNT_W'(RD_LEN)) && (^rd_frame) && !rd_frame[ADDR_W];
    end

    // Registered write strobe, job pulse and read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o     <= 1'b0;
            job_start_o <= 1'b0;
            rd_req_o    <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            rd_addr_o   <= '0;
        end else begin
            wr_en_o     <= wr_ok;
            job_start_o <= wr_ok && (frame_addr == ADDR_W'(JOB_ADDR));
            rd_req_o    <= rd_ok;
            if (wr_ok) begin
                wr_addr_o <= frame_addr;
                wr_data_o <= sr_q[DATA_W-1:0];
            end
            if (rd_ok) rd_addr_o <= rd_frame[ADDR_W-1:0];
        end
    end

    AST_WR_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(update_i)); // R1
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o); // R1
    AST_JOB_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        job_start_o |-> (wr_en_o && wr_addr_o == ADDR_W'(JOB_ADDR))); // R5
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_req_o)); // R3
endmodule

// File: rtl/ujb_result_fifo.sv
// Result queue filled by the compute core and drained by reads.
// Drops a push made while full (unless a pop frees a slot the same cycle)
// and sets a sticky overflow flag. Assumes DEPTH is a power of two.
module ujb_result_fifo
    import ujb_pkg::*;
#(
    parameter int DATA_W = UJB_DATA_W,
    parameter int DEPTH  = UJB_FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              empty_o,
    output logic              overflow_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              full, accept, take;

    // Push is accepted when there is room or a pop frees one.
    always_comb begin
        full    = (count_q == CNT_W'(DEPTH));
        empty_o = (count_q == '0);
        take    = pop_i && !empty_o;
        accept  = push_i && (!full || take);
        head_o  = mem_q[rptr_q];
    end

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (accept) mem_q[wptr_q] <= push_data_i;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q     <= '0;
            rptr_q     <= '0;
            count_q    <= '0;
            overflow_o <= 1'b0;
        end else begin
            if (accept) wptr_q <= wptr_q + 1'b1;
            if (take)   rptr_q <= rptr_q + 1'b1;
            case ({accept, take})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (push_i && !accept) overflow_o <= 1'b1;
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R7
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R6
endmodule

// File: rtl/ujb_readout.sv
// Holds a pending read request and, at capture, loads the register value,
// the FIFO head or all ones into the output shifter, popping the FIFO
// once per read of the result address. TDO is the shifter's bit 0.
module ujb_readout
    import ujb_pkg::*;
#(
    parameter int DATA_W      = UJB_DATA_W,
    parameter int ADDR_W      = UJB_ADDR_W,
    parameter int RESULT_ADDR = UJB_RESULT_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] reg_data_i,
    input  logic [DATA_W-1:0] fifo_head_i,
    input  logic              fifo_empty_i,
    output logic              pop_o,
    output logic              tdo_o
);
    logic              pending_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] load_val;
    logic              sel_fifo;

    // Choose the word to load and whether this capture pops the FIFO.
    always_comb begin
        sel_fifo = (rd_addr_i == ADDR_W'(RESULT_ADDR));
        pop_o    = capture_i && pending_q && sel_fifo && !fifo_empty_i;
        if (!pending_q)        load_val = '1;
        else if (!sel_fifo)    load_val = reg_data_i;
        else if (fifo_empty_i) load_val = '1;
        else                   load_val = fifo_head_i;
        tdo_o = out_q[0];
    end

    // Pending flag: set by a request, consumed by the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending_q <= 1'b0;
        else if (rd_req_i)  pending_q <= 1'b1;
        else if (capture_i) pending_q <= 1'b0;
    end

    // Output shifter: load on capture, shift right filling ones.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_q <= '1;
        else if (capture_i) out_q <= load_val;
        else if (shift_i)   out_q <= {1'b1, out_q[DATA_W-1:1]};
    end

    AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !capture_i) |=> out_q[DATA_W-1]); // R4
    AST_POP_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> !pending_q); // R6
endmodule

// File: rtl/jtag_regbridge.sv
// Top of the JTAG user-register bridge: frame decoder, result FIFO and
// read-out shifter. The register bank is external; its read port is
// combinational on reg_rd_addr.
module jtag_regbridge
    import ujb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dr_capture,
    input  logic                  dr_shift,
    input  logic                  dr_update,
    input  logic                  tdi,
    output logic                  tdo,
    output logic                  reg_wr_en,
    output logic [UJB_ADDR_W-1:0] reg_wr_addr,
    output logic [UJB_DATA_W-1:0] reg_wr_data,
    output logic                  job_start,
    output logic [UJB_ADDR_W-1:0] reg_rd_addr,
    input  logic [UJB_DATA_W-1:0] reg_rd_data,
    input  logic                  result_valid,
    input  logic [UJB_DATA_W-1:0] result_data,
    output logic                  result_overflow
);
    logic                  rd_req;
    logic                  fifo_pop, fifo_empty;
    logic [UJB_DATA_W-1:0] fifo_head;

    ujb_frame_rx #(.DATA_W(UJB_DATA_W), .ADDR_W(UJB_ADDR_W), .JOB_ADDR(UJB_JOB_ADDR)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .capture_i(dr_capture), .shift_i(dr_shift), .update_i(dr_update), .tdi_i(tdi),
        .wr_en_o(reg_wr_en), .wr_addr_o(reg_wr_addr), .wr_data_o(reg_wr_data),
        .job_start_o(job_start), .rd_req_o(rd_req), .rd_addr_o(reg_rd_addr)
    );

    ujb_result_fifo #(.DATA_W(UJB_DATA_W), .DEPTH(UJB_FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(result_valid), .push_data_i(result_data), .pop_i(fifo_pop),
        .head_o(fifo_head), .empty_o(fifo_empty), .overflow_o(result_overflow)
    );

    ujb_readout #(.DATA_W(UJB_DATA_W), .ADDR_W(UJB_ADDR_W), .RESULT_ADDR(UJB_RESULT_ADDR)) u_out (
        .clk(clk), .rst_n(rst_n),
        .capture_i(dr_capture), .shift_i(dr_shift),
        .rd_req_i(rd_req), .rd_addr_i(reg_rd_addr), .reg_data_i(reg_rd_data),
        .fifo_head_i(fifo_head), .fifo_empty_i(fifo_empty),
        .pop_o(fifo_pop), .tdo_o(tdo)
    );
endmodule

// File: tb/jtag_regbridge_bench.sv
// Bench for the JTAG user-register bridge: directed corners plus seeded
// random write/read traffic, checked against a bench-side model.
module jtag_regbridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        reg_wr_en, job_start, result_overflow;
    logic [3:0]  reg_wr_addr, reg_rd_addr;
    logic [31:0] reg_wr_data, reg_rd_data;
    logic        result_valid = 1'b0;
    logic [31:0] result_data = '0;

    logic [31:0] bank [16];
    logic [31:0] exp_bank [16];
    logic [31:0] q [$];
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    jtag_regbridge u_jtag_regbridge (
        .clk(clk), .rst_n(rst_n),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdi(tdi), .tdo(tdo),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .job_start(job_start), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .result_valid(result_valid), .result_data(result_data),
        .result_overflow(result_overflow)
    );

    // External register bank driven by the bridge's write port.
    assign reg_rd_data = bank[reg_rd_addr];
    always_ff @(posedge clk) if (reg_wr_en) bank[reg_wr_addr] <= reg_wr_data;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [37:0] mk_wr(input logic [3:0] a, input logic [31:0] d,
                                          input logic flag, input logic bad);
        logic [37:0] f;
        f[31:0] = d; f[35:32] = a; f[36] = flag;
        f[37] = ~(^f[36:0]) ^ bad;
        return f;
    endfunction

    function automatic logic [37:0] mk_rd(input logic [3:0] a, input logic bad);
        logic [37:0] f = '0;
        f[3:0] = a; f[4] = 1'b0;
        f[5] = ~(^f[4:0]) ^ bad;
        return f;
    endfunction

    // One DR scan: capture, len shifts, update; returns at the edge after update.
    task automatic scan(input logic [37:0] bits, input int len, output logic [31:0] got);
        got = '1;
        @(negedge clk) dr_capture = 1'b1;
        @(negedge clk) dr_capture = 1'b0; dr_shift = 1'b1;
        for (int i = 0; i < len; i++) begin
            tdi = bits[i];
            if (i < 32) got[i] = tdo;
            @(negedge clk);
        end
        dr_shift = 1'b0;
        dr_update = 1'b1;
        @(negedge clk) dr_update = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d,
                            input logic flag, input logic bad);
        logic [31:0] g;
        logic ok;
        ok = flag && !bad;
        scan(mk_wr(a, d, flag, bad), 38, g);
        chk(bad ? "R2 bad parity write" : (flag ? "R1 write strobe" : "R3 flag clear"),
            {31'b0, reg_wr_en}, {31'b0, ok});
        chk("R5 job pulse", {31'b0, job_start}, {31'b0, ok && a == 4'd11});
        if (ok) begin
            chk("R1 write addr", {28'b0, reg_wr_addr}, {28'b0, a});
            chk("R1 write data", reg_wr_data, d);
            exp_bank[a] = d;
        end
        @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] a, input logic bad, input string req);
        logic [31:0] g, e;
        scan(mk_rd(a, bad), 6, g);
        chk("R3 read frame no write", {31'b0, reg_wr_en}, 32'b0);
        if (bad) e = '1;
        else if (a == 4'hE) e = (q.size() != 0) ? q.pop_front() : 32'hFFFF_FFFF;
        else e = exp_bank[a];
        scan('0, 32, g);
        chk(req, g, e);
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk) result_valid = 1'b1; result_data = d;
        @(negedge clk) result_valid = 1'b0;
        if (q.size() < 16) q.push_back(d);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] g, r;
        for (int i = 0; i < 16; i++) begin bank[i] = '0; exp_bank[i] = '0; end
        r = $urandom(32'd20240);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset tdo", {31'b0, tdo}, 32'd1);
        chk("R8 reset wr_en", {31'b0, reg_wr_en}, 32'd0);
        chk("R8 reset job", {31'b0, job_start}, 32'd0);
        chk("R8 reset overflow", {31'b0, result_overflow}, 32'd0);

        // R1 state and message words, R5 job trigger, clock word at 0xD
        for (int a = 1; a <= 10; a++) do_write(4'(a), 32'h1111_0000 * a + 32'(a), 1'b1, 1'b0);
        do_write(4'd11, 32'hCAFE_F00D, 1'b1, 1'b0);
        do_write(4'hD, 32'd190, 1'b1, 1'b0);
        for (int a = 1; a <= 13; a++) do_read(4'(a), 1'b0, "R4 readback");

        // R2 bad parity write ignored, value unchanged
        do_write(4'd2, 32'hDEAD_BEEF, 1'b1, 1'b1);
        do_read(4'd2, 1'b0, "R2 unchanged after bad write");
        // R3 flag clear and wrong length ignored
        do_write(4'd3, 32'h0BAD_0BAD, 1'b0, 1'b0);
        do_read(4'd3, 1'b0, "R3 unchanged after flag clear");
        scan(mk_wr(4'd4, 32'h5555_AAAA, 1'b1, 1'b0), 20, g);
        chk("R3 short frame", {31'b0, reg_wr_en}, 32'd0);
        do_read(4'd4, 1'b0, "R3 unchanged after short frame");
        // R2 bad parity read, R8 capture with nothing pending
        do_read(4'd5, 1'b1, "R2 bad parity read gives ones");
        scan('0, 32, g);
        chk("R8 idle capture ones", g, 32'hFFFF_FFFF);

        // R6 FIFO order and empty behaviour
        do_read(4'hE, 1'b0, "R6 empty fifo");
        push(32'hA0A0_0001); push(32'hA0A0_0002); push(32'hA0A0_0003);
        for (int i = 0; i < 4; i++) do_read(4'hE, 1'b0, "R6 fifo pop");
        // R7 overflow
        for (int i = 0; i < 17; i++) push(32'hB000_0000 + 32'(i));
        @(negedge clk);
        chk("R7 overflow set", {31'b0, result_overflow}, 32'd1);
        for (int i = 0; i < 17; i++) do_read(4'hE, 1'b0, "R7 fifo drain");
        chk("R7 overflow sticky", {31'b0, result_overflow}, 32'd1);

        // Random traffic
        for (int k = 0; k < 40; k++) begin
            logic [3:0] a;
            a = 4'($urandom % 15);
            if (a == 4'hE) a = 4'hF;
            do_write(a, $urandom, 1'b1, ($urandom % 8) == 0);
            if (k % 5 == 0) push($urandom);
            a = 4'($urandom % 16);
            do_read(a, ($urandom % 8) == 0, "R4 random read");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule